// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block is the device-side reply engine for a low-speed or full-speed USB control endpoint. A packet receiver hands it one decoded event per packet: a token (SETUP, OUT, IN), a DATA packet with its byte count and CRC verdict, or a host ACK. From these events and the current stage of the control transfer, the block picks the single reply the device owes the host. That reply is ACK, NAK, STALL, or the start of a DATA packet. The block then passes the reply to the transmitter as a one-cycle request.

Firmware arms the endpoint with a byte count once the data for the next IN is fully staged. Until then, the block answers IN tokens with NAK by itself, and it does so for as many retries as the host makes. All replies are bound by the bus turnaround budget. The clock runs in half-bit units. The transmitter must accept the reply within 15 half-bit ticks of the event, or within 13 when the device has a detachable cable. If it does not, the reply is dropped rather than sent late, and a one-cycle error flag is raised.

Top module: `ctl_ep_responder`

## Requirements
- R1: After reset, tx_req, xfer_done and ta_err are low, armed is 0 and stage reads 0 (idle).
- R2: An IN token (rx_pid 3) received while stage is idle is answered with STALL (tx_kind 3).
- R3: A SETUP token (rx_pid 1) moves stage to 1. A following DATA packet (rx_pid 4) with rx_crc_ok high is answered with ACK (tx_kind 1). That DATA packet clears armed even if firmware had armed the endpoint, and moves stage to 2 (data stage).
- R4: A DATA packet with rx_crc_ok low gets no reply of any kind, and stage stays where it was.
- R5: An IN token in stage 2 with armed at 0 is answered with NAK (tx_kind 2). Any number of repeats is answered the same way, and stage stays 2.
- R6: A pulse on fw_arm sets armed and stores fw_len. An IN token in stage 2 or 3 with armed at 1 is answered with DATA (tx_kind 4) and tx_len equal to the stored count, and stage becomes 3. If the host then sends another IN without an ACK, the same count is offered again.
- R7: A host ACK (rx_pid 5) in stage 3 clears armed and returns stage to 2.
- R8: An OUT token (rx_pid 2) in stage 2 or 3 moves stage to 4 with no reply. A following zero-length DATA packet with good CRC is answered with ACK, pulses xfer_done for one cycle and returns stage to 0.
- R9: A reply is requested only if tx_ready is sampled high on one of the first 15 clock edges after the event edge with cable_detach low. With cable_detach high the window is the first 13 edges. The default is one clock per half-bit.
- R10: When tx_ready stays low through the whole window of R9, no reply is requested for that event, and ta_err pulses high for one cycle.
- R11: tx_req is a one-cycle pulse that never coincides with ta_err. tx_kind and tx_len are valid with it. A new receiver event cancels any reply still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per half-bit time by default |
| rst | input | 1 | Synchronous active-high reset |
| cable_detach | input | 1 | High selects the shorter 13 half-bit turnaround budget |
| rx_valid | input | 1 | One-cycle strobe marking the end of a received packet |
| rx_pid | input | 3 | Event code: 1 SETUP, 2 OUT, 3 IN, 4 DATA, 5 ACK |
| rx_len | input | LEN_W | Byte count of a received DATA packet |
| rx_crc_ok | input | 1 | CRC verdict of a received DATA packet |
| fw_arm | input | 1 | Firmware pulse: IN data is fully staged |
| fw_len | input | LEN_W | Byte count of the staged IN data |
| tx_ready | input | 1 | Transmitter can start a packet now |
| tx_req | output | 1 | One-cycle reply request to the transmitter |
| tx_kind | output | 3 | Reply code: 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| tx_len | output | LEN_W | Byte count for a DATA reply |
| armed | output | 1 | Staged IN data not yet acknowledged by the host |
| stage | output | 3 | 0 idle, 1 setup, 2 data, 3 data sent, 4 status |
| xfer_done | output | 1 | One-cycle pulse when the status stage is acknowledged |
| ta_err | output | 1 | One-cycle pulse on a missed turnaround deadline |

## Verification
A wrong stage register shows on the next token as the wrong handshake kind. A STALL or silence appears where a NAK or DATA was due, or an ACK goes missing at the status stage. These show at most one event later, and the stage port shows them at once. A wrong armed flag or stored length shows on the very next IN as a NAK in place of DATA or as a wrong tx_len. An off-by-one turnaround count shows only at the last edge of the window, so the bench raises tx_ready exactly on the final allowed edge and one edge later, for both cable settings.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_SETUP = 3'd1,
    EV_OUT   = 3'd2,
    EV_IN    = 3'd3,
    EV_DATA  = 3'd4,
    EV_ACK   = 3'd5
  } rx_ev_e;

  typedef enum logic [2:0] {
    RP_NONE  = 3'd0,
    RP_ACK   = 3'd1,
    RP_NAK   = 3'd2,
    RP_STALL = 3'd3,
    RP_DATA  = 3'd4
  } reply_e;

  typedef enum logic [2:0] {
    SG_IDLE   = 3'd0,
    SG_SETUP  = 3'd1,
    SG_DATA   = 3'd2,
    SG_SENT   = 3'd3,
    SG_STATUS = 3'd4
  } stage_e;
endpackage

// File: rtl/ctl_ep_tick.sv
module ctl_ep_tick #(
  parameter int CLKS_PER_HB = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic hb_tick
);
  generate
    if (CLKS_PER_HB <= 1) begin : g_direct
      assign hb_tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLKS_PER_HB);
      localparam logic [DW-1:0] LAST = DW'(CLKS_PER_HB - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign hb_tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ctl_ep_stage.sv
module ctl_ep_stage
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  rx_ev_e           rx_ev,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_crc_ok,
  input  logic             fw_arm,
  input  logic [LEN_W-1:0] fw_len,
  output logic             dec_valid,
  output reply_e           dec_kind,
  output logic [LEN_W-1:0] dec_len,
  output logic             armed_q,
  output stage_e           stage_q,
  output logic             done_q
);
  logic [LEN_W-1:0] arm_len_q;
  stage_e           stage_d;
  logic             clr_arm;
  logic             fin;

  always_comb begin
    stage_d   = stage_q;
    dec_valid = 1'b0;
    dec_kind  = RP_NONE;
    dec_len   = '0;
    clr_arm   = 1'b0;
    fin       = 1'b0;
    if (rx_valid) begin
      unique case (rx_ev)
        EV_SETUP: stage_d = SG_SETUP;
        EV_DATA: begin
          if (rx_crc_ok && stage_q == SG_SETUP) begin
            dec_valid = 1'b1;
            dec_kind  = RP_ACK;
            clr_arm   = 1'b1;
            stage_d   = SG_DATA;
          end else if (rx_crc_ok && stage_q == SG_STATUS && rx_len == '0) begin
            dec_valid = 1'b1;
            dec_kind  = RP_ACK;
            fin       = 1'b1;
            stage_d   = SG_IDLE;
          end
        end
        EV_IN: begin
          if (stage_q == SG_IDLE) begin
            dec_valid = 1'b1;
            dec_kind  = RP_STALL;
          end else if (stage_q == SG_DATA || stage_q == SG_SENT) begin
            dec_valid = 1'b1;
            if (armed_q) begin
              dec_kind = RP_DATA;
              dec_len  = arm_len_q;
              stage_d  = SG_SENT;
            end else begin
              dec_kind = RP_NAK;
            end
          end
        end
        EV_OUT: begin
          if (stage_q == SG_DATA || stage_q == SG_SENT) stage_d = SG_STATUS;
        end
        EV_ACK: begin
          if (stage_q == SG_SENT) begin
            clr_arm = 1'b1;
            stage_d = SG_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= SG_IDLE;
      armed_q   <= 1'b0;
      arm_len_q <= '0;
      done_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      done_q  <= fin;
      if (clr_arm && stage_q == SG_SETUP) begin
        armed_q <= 1'b0;
      end else if (fw_arm) begin
        armed_q   <= 1'b1;
        arm_len_q <= fw_len;
      end else if (clr_arm) begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctl_ep_turnaround.sv
module ctl_ep_turnaround
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W      = 7,
  parameter int LIM_FIXED  = 15,
  parameter int LIM_DETACH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cable_detach,
  input  logic             hb_tick,
  input  logic             cancel,
  input  logic             dec_valid,
  input  reply_e           dec_kind,
  input  logic [LEN_W-1:0] dec_len,
  input  logic             tx_ready,
  output logic             tx_req_q,
  output reply_e           tx_kind_q,
  output logic [LEN_W-1:0] tx_len_q,
  output logic             miss_q
);
  localparam int CW = $clog2(LIM_FIXED + 1);
  localparam logic [CW-1:0] LAST_FIX = CW'(LIM_FIXED - 1);
  localparam logic [CW-1:0] LAST_DET = CW'(LIM_DETACH - 1);

  logic             pend_q;
  reply_e           pend_kind_q;
  logic [LEN_W-1:0] pend_len_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    last_cnt;

  assign last_cnt = cable_detach ? LAST_DET : LAST_FIX;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_kind_q <= RP_NONE;
      pend_len_q  <= '0;
      cnt_q       <= '0;
      tx_req_q    <= 1'b0;
      tx_kind_q   <= RP_NONE;
      tx_len_q    <= '0;
      miss_q      <= 1'b0;
    end else begin
      tx_req_q <= 1'b0;
      miss_q   <= 1'b0;
      if (cancel) begin
        pend_q      <= dec_valid;
        pend_kind_q <= dec_kind;
        pend_len_q  <= dec_len;
        cnt_q       <= '0;
      end else if (pend_q) begin
        if (tx_ready) begin
          tx_req_q  <= 1'b1;
          tx_kind_q <= pend_kind_q;
          tx_len_q  <= pend_len_q;
          pend_q    <= 1'b0;
        end else if (hb_tick) begin
          if (cnt_q >= last_cnt) begin
            pend_q <= 1'b0;
            miss_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W       = 7,
  parameter int LIM_FIXED   = 15,
  parameter int LIM_DETACH  = 13,
  parameter int CLKS_PER_HB = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cable_detach,
  input  logic             rx_valid,
  input  logic [2:0]       rx_pid,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_crc_ok,
  input  logic             fw_arm,
  input  logic [LEN_W-1:0] fw_len,
  input  logic             tx_ready,
  output logic             tx_req,
  output logic [2:0]       tx_kind,
  output logic [LEN_W-1:0] tx_len,
  output logic             armed,
  output logic [2:0]       stage,
  output logic             xfer_done,
  output logic             ta_err
);
  logic             hb_tick;
  logic             dec_valid;
  reply_e           dec_kind;
  logic [LEN_W-1:0] dec_len;
  stage_e           stage_w;
  reply_e           kind_w;

  ctl_ep_tick #(.CLKS_PER_HB(CLKS_PER_HB)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (rx_valid),
    .hb_tick (hb_tick)
  );

  ctl_ep_stage #(.LEN_W(LEN_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_ev     (rx_ev_e'(rx_pid)),
    .rx_len    (rx_len),
    .rx_crc_ok (rx_crc_ok),
    .fw_arm    (fw_arm),
    .fw_len    (fw_len),
    .dec_valid (dec_valid),
    .dec_kind  (dec_kind),
    .dec_len   (dec_len),
    .armed_q   (armed),
    .stage_q   (stage_w),
    .done_q    (xfer_done)
  );

  ctl_ep_turnaround #(
    .LEN_W      (LEN_W),
    .LIM_FIXED  (LIM_FIXED),
    .LIM_DETACH (LIM_DETACH)
  ) u_ta (
    .clk          (clk),
    .rst          (rst),
    .cable_detach (cable_detach),
    .hb_tick      (hb_tick),
    .cancel       (rx_valid),
    .dec_valid    (dec_valid),
    .dec_kind     (dec_kind),
    .dec_len      (dec_len),
    .tx_ready     (tx_ready),
    .tx_req_q     (tx_req),
    .tx_kind_q    (kind_w),
    .tx_len_q     (tx_len),
    .miss_q       (ta_err)
  );

  assign stage   = stage_w;
  assign tx_kind = kind_w;
endmodule

// File: rtl/ctl_ep_responder_chk.sv
module ctl_ep_responder_chk #(
  parameter int LEN_W       = 7,
  parameter int LIM_FIXED   = 15,
  parameter int CLKS_PER_HB = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic [2:0]       rx_pid,
  input logic             rx_crc_ok,
  input logic             tx_req,
  input logic [2:0]       tx_kind,
  input logic             armed,
  input logic [2:0]       stage,
  input logic             xfer_done,
  input logic             ta_err
);
  localparam int BOUND = (LIM_FIXED + 1) * CLKS_PER_HB;
  logic [15:0] since_ev;

  always_ff @(posedge clk) begin
    if (rst) since_ev <= 16'hFFFF;
    else if (rx_valid) since_ev <= '0;
    else if (since_ev != 16'hFFFF) since_ev <= since_ev + 1'b1;
  end

  // R11
  req_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_req && ta_err));

  // R11
  req_kind_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (tx_kind >= 3'd1 && tx_kind <= 3'd4));

  // R6
  data_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_kind == 3'd4) |-> armed);

  // R8
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (stage == 3'd0));

  // R4
  bad_crc_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_pid == 3'd4 && !rx_crc_ok) |=> ##1 !tx_req);

  // R9
  deadline_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (since_ev <= 16'(BOUND)));

  // R1
  stage_legal_chk: assert property (@(posedge clk) disable iff (rst)
    stage <= 3'd4);
endmodule

bind ctl_ep_responder ctl_ep_responder_chk #(
  .LEN_W       (LEN_W),
  .LIM_FIXED   (LIM_FIXED),
  .CLKS_PER_HB (CLKS_PER_HB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .rx_pid    (rx_pid),
  .rx_crc_ok (rx_crc_ok),
  .tx_req    (tx_req),
  .tx_kind   (tx_kind),
  .armed     (armed),
  .stage     (stage),
  .xfer_done (xfer_done),
  .ta_err    (ta_err)
);

// File: tb/ctl_ep_responder_bench.sv
`timescale 1ns/1ps
module ctl_ep_responder_bench;
  localparam int LEN_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cable_detach = 1'b0;
  logic             rx_valid = 1'b0;
  logic [2:0]       rx_pid = 3'd0;
  logic [LEN_W-1:0] rx_len = '0;
  logic             rx_crc_ok = 1'b0;
  logic             fw_arm = 1'b0;
  logic [LEN_W-1:0] fw_len = '0;
  logic             tx_ready = 1'b1;
  logic             tx_req;
  logic [2:0]       tx_kind;
  logic [LEN_W-1:0] tx_len;
  logic             armed;
  logic [2:0]       stage;
  logic             xfer_done;
  logic             ta_err;

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;
  int n_miss = 0;
  bit finished = 1'b0;

  int    q_kind[$];
  int    q_len[$];
  string q_tag[$];

  always #4 clk = ~clk;

  ctl_ep_responder u_ctl_ep_responder (
    .clk(clk), .rst(rst), .cable_detach(cable_detach),
    .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_len(rx_len), .rx_crc_ok(rx_crc_ok),
    .fw_arm(fw_arm), .fw_len(fw_len), .tx_ready(tx_ready),
    .tx_req(tx_req), .tx_kind(tx_kind), .tx_len(tx_len),
    .armed(armed), .stage(stage), .xfer_done(xfer_done), .ta_err(ta_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_reply(input int kind, input int len, input string tag);
    q_kind.push_back(kind);
    q_len.push_back(len);
    q_tag.push_back(tag);
  endtask

  // Monitor: pop expected replies as the design requests them.
  always @(negedge clk) begin
    if (!rst) begin
      if (xfer_done) n_done++;
      if (ta_err) n_miss++;
      if (tx_req) begin
        if (q_kind.size() == 0) begin
          chk(1'b0, "R11 unexpected reply", int'(tx_kind), 0);
        end else begin
          automatic int    ek = q_kind.pop_front();
          automatic int    el = q_len.pop_front();
          automatic string et = q_tag.pop_front();
          chk(int'(tx_kind) == ek, {et, " kind"}, int'(tx_kind), ek);
          if (ek == 4) chk(int'(tx_len) == el, {et, " len"}, int'(tx_len), el);
        end
      end
    end
  end

  task automatic host(input int pid, input int len, input bit crc);
    @(negedge clk);
    rx_valid  = 1'b1;
    rx_pid    = 3'(pid);
    rx_len    = LEN_W'(len);
    rx_crc_ok = crc;
    @(negedge clk);
    rx_valid  = 1'b0;
    rx_crc_ok = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (4) @(negedge clk);
    chk(q_kind.size() == 0, {req, " pending replies"}, q_kind.size(), 0);
    q_kind.delete(); q_len.delete(); q_tag.delete();
  endtask

  task automatic arm(input int len);
    @(negedge clk);
    fw_arm = 1'b1;
    fw_len = LEN_W'(len);
    @(negedge clk);
    fw_arm = 1'b0;
  endtask

  // Raise tx_ready after n negedges following the event.
  task automatic late_in(input int n, input bit sent, input string req);
    int miss0;
    miss0 = n_miss;
    tx_ready = 1'b0;
    if (sent) expect_reply(3, 0, req);
    host(3, 0, 1'b0);
    repeat (n) @(negedge clk);
    tx_ready = 1'b1;
    settle(req);
    chk(n_miss - miss0 == (sent ? 0 : 1), {req, " ta_err pulses"}, n_miss - miss0, sent ? 0 : 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);
    chk(stage == 3'd0, "R1 stage", stage, 0);
    chk(armed == 1'b0, "R1 armed", armed, 0);
    chk(xfer_done == 1'b0 && ta_err == 1'b0, "R1 flags", xfer_done | ta_err, 0);

    // R2
    expect_reply(3, 0, "R2 stall in idle");
    host(3, 0, 1'b0);
    settle("R2");

    // R3 + R4: setup with a bad then good CRC
    host(1, 0, 1'b0);
    chk(stage == 3'd1, "R3 setup stage", stage, 1);
    host(4, 8, 1'b0);
    settle("R4");
    chk(stage == 3'd1, "R4 stage after bad crc", stage, 1);
    expect_reply(1, 0, "R3 setup ack");
    host(4, 8, 1'b1);
    settle("R3");
    chk(stage == 3'd2, "R3 data stage", stage, 2);

    // R5: many NAKs, no abort
    for (int i = 0; i < 20; i++) begin
      expect_reply(2, 0, "R5 nak");
      host(3, 0, 1'b0);
    end
    settle("R5");
    chk(stage == 3'd2, "R5 stage kept", stage, 2);

    // R6 + R7
    arm(5);
    chk(armed == 1'b1, "R6 armed set", armed, 1);
    expect_reply(4, 5, "R6 data");
    host(3, 0, 1'b0);
    settle("R6");
    chk(stage == 3'd3, "R6 stage sent", stage, 3);
    expect_reply(4, 5, "R6 reoffer");
    host(3, 0, 1'b0);
    settle("R6 reoffer");
    chk(armed == 1'b1, "R6 armed kept", armed, 1);
    host(5, 0, 1'b0);
    settle("R7");
    chk(armed == 1'b0, "R7 armed cleared", armed, 0);
    chk(stage == 3'd2, "R7 stage", stage, 2);
    expect_reply(2, 0, "R7 nak after ack");
    host(3, 0, 1'b0);
    settle("R7 nak");

    // R8: status stage
    arm(3);
    expect_reply(4, 3, "R8 last data");
    host(3, 0, 1'b0);
    host(5, 0, 1'b0);
    host(2, 0, 1'b0);
    settle("R8 out");
    chk(stage == 3'd4, "R8 status stage", stage, 4);
    host(4, 0, 1'b0);
    settle("R4 status bad crc");
    chk(stage == 3'd4, "R4 status kept", stage, 4);
    expect_reply(1, 0, "R8 status ack");
    host(4, 0, 1'b1);
    settle("R8");
    chk(n_done == 1, "R8 xfer_done", n_done, 1);
    chk(stage == 3'd0, "R8 idle", stage, 0);

    // R3: setup clears stale armed data
    arm(4);
    host(1, 0, 1'b0);
    expect_reply(1, 0, "R3 rearm ack");
    host(4, 8, 1'b1);
    settle("R3 stale");
    chk(armed == 1'b0, "R3 stale cleared", armed, 0);
    expect_reply(2, 0, "R3 nak after setup");
    host(3, 0, 1'b0);
    settle("R3 nak");
    host(2, 0, 1'b0);
    expect_reply(1, 0, "R8 status ack 2");
    host(4, 0, 1'b1);
    settle("R8 second");

    // R9 + R10: turnaround windows
    cable_detach = 1'b0;
    late_in(14, 1'b1, "R9 fixed last edge");
    late_in(15, 1'b0, "R10 fixed missed");
    cable_detach = 1'b1;
    late_in(12, 1'b1, "R9 detach last edge");
    late_in(13, 1'b0, "R10 detach missed");
    cable_detach = 1'b0;

    // R11: a new event cancels a pending reply
    tx_ready = 1'b0;
    host(3, 0, 1'b0);
    host(1, 0, 1'b0);
    repeat (3) @(negedge clk);
    tx_ready = 1'b1;
    settle("R11 cancel");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule